// File: doc/BRIEF.md
# Logical-to-Physical DMA Channel Binder

This block shares a small pool of physical DMA channels among a larger population of logical requesters. A requester that has work is placed in a first-come-first-served waiting line. Whenever physical channels are free, an allocation pass walks the channels from index 0 upward. Each free channel it finds is bound to the requester at the head of the line. Every binding is reported on a grant output. The channels granted in a pass receive their start pulses together, once the pass has ended.

A binding lasts across consecutive jobs. When a channel reports completion and its requester still has another job, the channel restarts at once with no new arbitration. When the requester has run dry, the channel is released. Software-style control arrives as one command per cycle: issue, pause, resume or terminate, each aimed at one requester. Paused requesters leave the line. Paused bound requesters freeze their channel. Terminated requesters lose both their place in the line and their channel.

Descriptor fetch, data movement and register access belong to other blocks.

Top module: `vchan_alloc`

## Requirements
- R1: After reset no channel is bound or paused, and grant_vld_o, ch_start_o and ch_stop_o are all low.
- R2: An issue command (cmd_op_i = 0) appends the requester to the tail of the waiting line only when it is neither bound nor already waiting; otherwise it has no effect.
- R3: Waiting requesters are granted oldest first, and each grant takes the lowest-numbered channel that is free during the pass.
- R4: A pass grants at most one channel per cycle, reported by grant_vld_o with grant_req_o and grant_ch_o. All channels granted in one pass pulse ch_start_o in the same single cycle, which comes after the last grant of that pass.
- R5: A completion (ch_done_i) with ch_more_i high keeps the binding, pulses ch_start_o on that channel in the next cycle and produces no grant.
- R6: A completion with ch_more_i low clears the channel's binding in the next cycle, so a later pass can grant the channel again.
- R7: A pause command (cmd_op_i = 1) removes an unbound requester from the waiting line. For a bound requester it raises ch_pause_o of its channel instead.
- R8: A resume command (cmd_op_i = 2) clears ch_pause_o of a bound requester's channel. For an unbound requester that is not waiting, it appends the requester to the tail only when cmd_work_i is high.
- R9: A terminate command (cmd_op_i = 3) removes the requester from the waiting line. If the requester is bound, ch_stop_o pulses for one cycle on its channel, and that channel's binding and pause state are cleared.
- R10: When a release-type completion and an issue from the same requester fall in the same cycle, the completion is applied first, and the requester re-enters the waiting line.
- R11: A cycle that carries a command holds the allocation scan in place. Commands whose requester index is NUM_REQ or higher are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_vld_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | 0 issue, 1 pause, 2 resume, 3 terminate |
| cmd_req_i | input | $clog2(NUM_REQ) | Target requester index |
| cmd_work_i | input | 1 | Requester still holds queued work (used by resume) |
| ch_done_i | input | NUM_CH | Per-channel job completion pulse |
| ch_more_i | input | NUM_CH | Bound requester has a further job, qualified by ch_done_i |
| grant_vld_o | output | 1 | A binding was made in the previous cycle |
| grant_req_o | output | $clog2(NUM_REQ) | Requester of the binding |
| grant_ch_o | output | $clog2(NUM_CH) | Channel of the binding |
| ch_start_o | output | NUM_CH | Per-channel start pulse |
| ch_stop_o | output | NUM_CH | Per-channel stop pulse from terminate |
| ch_pause_o | output | NUM_CH | Per-channel pause level |
| ch_bound_o | output | NUM_CH | Per-channel bound level |

## Verification
Two pairs of events can land in the same cycle. The first pair is a channel completion and a command from the requester that owns the channel. The bench drives a release-type completion together with an issue from the same requester. It judges the order by whether that requester is granted again; a restart-type completion paired with an issue must instead yield a start pulse and no grant. The second pair is a command and an allocation step. The bench keeps commands flowing while a pass is underway, confirms that no grant appears during those cycles, and then checks that the delayed grants still arrive in arrival order on the lowest free channels.

// File: rtl/vca_pkg.sv
package vca_pkg;
  typedef enum logic [1:0] {
    OP_ISSUE  = 2'd0,
    OP_PAUSE  = 2'd1,
    OP_RESUME = 2'd2,
    OP_TERM   = 2'd3
  } vca_op_e;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_SCAN = 2'd1,
    SC_FIRE = 2'd2
  } scan_st_e;
endpackage

// File: rtl/vca_queue.sv
module vca_queue #(
  parameter int DEPTH = 53,
  parameter int IDW   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [IDW-1:0]   push_id_i,
  input  logic             del_i,
  input  logic [IDW-1:0]   del_id_i,
  output logic [IDW-1:0]   head_o,
  output logic             empty_o,
  output logic [DEPTH-1:0] queued_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [IDW-1:0]   q_q   [DEPTH];
  logic [IDW-1:0]   q_nxt [DEPTH];
  logic [CW-1:0]    cnt_q, cnt_del;
  logic [DEPTH-1:0] match, shift, queued_q, queued_nxt;
  logic             found;

  // locate deleted entry; everything at or above it slides down one slot
  always_comb begin
    for (int k = 0; k < DEPTH; k++)
      match[k] = del_i && (CW'(k) < cnt_q) && (q_q[k] == del_id_i);
    shift[0] = match[0];
    for (int k = 1; k < DEPTH; k++)
      shift[k] = shift[k-1] | match[k];
    found   = shift[DEPTH-1];
    cnt_del = cnt_q - CW'(found);
  end

  always_comb begin
    for (int k = 0; k < DEPTH - 1; k++)
      q_nxt[k] = shift[k] ? q_q[k+1] : q_q[k];
    q_nxt[DEPTH-1] = shift[DEPTH-1] ? '0 : q_q[DEPTH-1];
    for (int k = 0; k < DEPTH; k++)
      if (push_i && cnt_del == CW'(k)) q_nxt[k] = push_id_i;
    queued_nxt = queued_q;
    for (int r = 0; r < DEPTH; r++) begin
      if (found && del_id_i == IDW'(r)) queued_nxt[r] = 1'b0;
      if (push_i && push_id_i == IDW'(r)) queued_nxt[r] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      queued_q <= '0;
      for (int k = 0; k < DEPTH; k++) q_q[k] <= '0;
    end else begin
      cnt_q    <= cnt_del + CW'(push_i);
      queued_q <= queued_nxt;
      for (int k = 0; k < DEPTH; k++) q_q[k] <= q_nxt[k];
    end
  end

  assign head_o   = q_q[0];
  assign empty_o  = (cnt_q == '0);
  assign queued_o = queued_q;

  AST_Q_NO_DUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !queued_q[push_id_i]); // R2
  AST_Q_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_del < CW'(DEPTH))); // R2
  AST_Q_FLAGS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(queued_q) == int'(cnt_q)); // R2
endmodule

// File: rtl/vca_chan_table.sv
module vca_chan_table import vca_pkg::*; #(
  parameter int NUM_CH = 16,
  parameter int IDW    = 6,
  parameter int CHW    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] more_i,
  input  logic              bind_i,
  input  logic [CHW-1:0]    bind_ch_i,
  input  logic [IDW-1:0]    bind_req_i,
  input  logic              cmd_ok_i,
  input  vca_op_e           cmd_op_i,
  input  logic [IDW-1:0]    cmd_req_i,
  output logic              req_bound_o,
  output logic [NUM_CH-1:0] restart_o,
  output logic [NUM_CH-1:0] kill_o,
  output logic [NUM_CH-1:0] bound_o,
  output logic [NUM_CH-1:0] pause_o,
  output logic [NUM_CH-1:0] stop_o
);
  logic [IDW-1:0]    owner_q [NUM_CH];
  logic [NUM_CH-1:0] bound_q, pause_q, stop_q;
  logic [NUM_CH-1:0] rel, keep, hit, t_hit, p_hit, r_hit;

  // completions are resolved before the command sees the binding
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      rel[c]  = bound_q[c] & done_i[c] & ~more_i[c];
      keep[c] = bound_q[c] & done_i[c] &  more_i[c];
      hit[c]  = cmd_ok_i & bound_q[c] & ~rel[c] & (owner_q[c] == cmd_req_i);
    end
    t_hit = hit & {NUM_CH{cmd_op_i == OP_TERM}};
    p_hit = hit & {NUM_CH{cmd_op_i == OP_PAUSE}};
    r_hit = hit & {NUM_CH{cmd_op_i == OP_RESUME}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bound_q <= '0;
      pause_q <= '0;
      stop_q  <= '0;
      for (int c = 0; c < NUM_CH; c++) owner_q[c] <= '0;
    end else begin
      stop_q <= t_hit;
      for (int c = 0; c < NUM_CH; c++) begin
        if (bind_i && bind_ch_i == CHW'(c)) begin
          bound_q[c] <= 1'b1;
          pause_q[c] <= 1'b0;
          owner_q[c] <= bind_req_i;
        end else begin
          bound_q[c] <= bound_q[c] & ~rel[c] & ~t_hit[c];
          pause_q[c] <= (pause_q[c] | p_hit[c]) & ~(r_hit[c] | t_hit[c] | rel[c]);
        end
      end
    end
  end

  assign req_bound_o = |hit;
  assign restart_o   = keep & ~t_hit;
  assign kill_o      = rel | t_hit;
  assign bound_o     = bound_q;
  assign pause_o     = pause_q;
  assign stop_o      = stop_q;

  AST_BIND_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bind_i |-> !bound_q[bind_ch_i]); // R3
  AST_ONE_BINDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ok_i |-> $onehot0(hit)); // R2
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_PAUSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pause_q[c] |-> bound_q[c]); // R7
    AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_q[c] |-> (!bound_q[c] && !pause_q[c])); // R9
  end
endmodule

// File: rtl/vca_scan.sv
module vca_scan import vca_pkg::*; #(
  parameter int NUM_CH = 16,
  parameter int CHW    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              q_empty_i,
  input  logic [NUM_CH-1:0] bound_i,
  input  logic              stall_i,
  output logic              take_o,
  output logic [CHW-1:0]    ptr_o,
  output logic              fire_o,
  output logic [NUM_CH-1:0] fire_mask_o
);
  scan_st_e          st_q;
  logic [CHW-1:0]    ptr_q;
  logic [NUM_CH-1:0] amask_q;

  assign take_o = (st_q == SC_SCAN) && !stall_i && !q_empty_i && !bound_i[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SC_IDLE;
      ptr_q   <= '0;
      amask_q <= '0;
    end else begin
      unique case (st_q)
        SC_IDLE: begin
          if (!q_empty_i && !(&bound_i)) begin
            st_q  <= SC_SCAN;
            ptr_q <= '0;
          end
        end
        SC_SCAN: begin
          if (!stall_i) begin
            if (take_o) amask_q[ptr_q] <= 1'b1;
            // line drained or last channel visited: close the pass
            if (q_empty_i || ptr_q == CHW'(NUM_CH - 1)) st_q <= SC_FIRE;
            else ptr_q <= ptr_q + 1'b1;
          end
        end
        SC_FIRE: begin
          st_q    <= SC_IDLE;
          amask_q <= '0;
        end
        default: st_q <= SC_IDLE;
      endcase
    end
  end

  assign ptr_o       = ptr_q;
  assign fire_o      = (st_q == SC_FIRE);
  assign fire_mask_o = amask_q;

  AST_SCAN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SC_SCAN && stall_i) |=> ($stable(ptr_q) && $stable(amask_q))); // R11
endmodule

// File: rtl/vchan_alloc.sv
module vchan_alloc import vca_pkg::*; #(
  parameter int NUM_REQ = 53,
  parameter int NUM_CH  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_vld_i,
  input  logic [1:0]                 cmd_op_i,
  input  logic [$clog2(NUM_REQ)-1:0] cmd_req_i,
  input  logic                       cmd_work_i,
  input  logic [NUM_CH-1:0]          ch_done_i,
  input  logic [NUM_CH-1:0]          ch_more_i,
  output logic                       grant_vld_o,
  output logic [$clog2(NUM_REQ)-1:0] grant_req_o,
  output logic [$clog2(NUM_CH)-1:0]  grant_ch_o,
  output logic [NUM_CH-1:0]          ch_start_o,
  output logic [NUM_CH-1:0]          ch_stop_o,
  output logic [NUM_CH-1:0]          ch_pause_o,
  output logic [NUM_CH-1:0]          ch_bound_o
);
  localparam int RW   = $clog2(NUM_REQ);
  localparam int CHW  = $clog2(NUM_CH);
  localparam int RPAD = 1 << RW;

  vca_op_e           op;
  logic              cmd_ok, req_bound, is_queued, cmd_push, cmd_del;
  logic              take, q_empty, fire;
  logic [RW-1:0]     head;
  logic [CHW-1:0]    ptr;
  logic [NUM_REQ-1:0] q_queued;
  logic [RPAD-1:0]   q_pad;
  logic [NUM_CH-1:0] restart, kill, bound, fire_mask, start_nxt;

  assign op     = vca_op_e'(cmd_op_i);
  assign cmd_ok = cmd_vld_i && ({1'b0, cmd_req_i} < (RW + 1)'(NUM_REQ));

  always_comb begin
    q_pad = '0;
    q_pad[NUM_REQ-1:0] = q_queued;
  end
  assign is_queued = q_pad[cmd_req_i];

  assign cmd_push = cmd_ok && !req_bound && !is_queued &&
                    (op == OP_ISSUE || (op == OP_RESUME && cmd_work_i));
  assign cmd_del  = cmd_ok && is_queued && (op == OP_PAUSE || op == OP_TERM);

  vca_queue #(.DEPTH(NUM_REQ), .IDW(RW)) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (cmd_push),
    .push_id_i (cmd_req_i),
    .del_i     (cmd_del | take),
    .del_id_i  (take ? head : cmd_req_i),
    .head_o    (head),
    .empty_o   (q_empty),
    .queued_o  (q_queued)
  );

  vca_chan_table #(.NUM_CH(NUM_CH), .IDW(RW), .CHW(CHW)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (ch_done_i),
    .more_i      (ch_more_i),
    .bind_i      (take),
    .bind_ch_i   (ptr),
    .bind_req_i  (head),
    .cmd_ok_i    (cmd_ok),
    .cmd_op_i    (op),
    .cmd_req_i   (cmd_req_i),
    .req_bound_o (req_bound),
    .restart_o   (restart),
    .kill_o      (kill),
    .bound_o     (bound),
    .pause_o     (ch_pause_o),
    .stop_o      (ch_stop_o)
  );

  vca_scan #(.NUM_CH(NUM_CH), .CHW(CHW)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .q_empty_i   (q_empty),
    .bound_i     (bound),
    .stall_i     (cmd_vld_i),
    .take_o      (take),
    .ptr_o       (ptr),
    .fire_o      (fire),
    .fire_mask_o (fire_mask)
  );

  assign start_nxt = restart | ({NUM_CH{fire}} & fire_mask & bound & ~kill);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_vld_o <= 1'b0;
      grant_req_o <= '0;
      grant_ch_o  <= '0;
      ch_start_o  <= '0;
    end else begin
      grant_vld_o <= take;
      ch_start_o  <= start_nxt;
      if (take) begin
        grant_req_o <= head;
        grant_ch_o  <= ptr;
      end
    end
  end

  assign ch_bound_o = bound;

  AST_GRANT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> ch_bound_o[grant_ch_o]); // R3
  AST_START_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_start_o & ~ch_bound_o) == '0); // R5
  AST_START_STOP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_start_o & ch_stop_o) == '0); // R9
endmodule

// File: tb/vchan_alloc_test.sv
`timescale 1ns/1ps
module vchan_alloc_test;
  localparam int NR = 53;
  localparam int NC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_vld = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [5:0]  cmd_req = '0;
  logic        cmd_work = 1'b0;
  logic [NC-1:0] ch_done = '0, ch_more = '0;
  logic        grant_vld;
  logic [5:0]  grant_req;
  logic [3:0]  grant_ch;
  logic [NC-1:0] ch_start, ch_stop, ch_pause, ch_bound;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, g_n = 0;
  int gl_req [256];
  int gl_ch  [256];
  int gl_cyc [256];
  int st_cnt [NC];
  int st_cyc [NC];

  always #2 clk = ~clk;

  vchan_alloc #(.NUM_REQ(NR), .NUM_CH(NC)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_vld_i(cmd_vld), .cmd_op_i(cmd_op), .cmd_req_i(cmd_req), .cmd_work_i(cmd_work),
    .ch_done_i(ch_done), .ch_more_i(ch_more),
    .grant_vld_o(grant_vld), .grant_req_o(grant_req), .grant_ch_o(grant_ch),
    .ch_start_o(ch_start), .ch_stop_o(ch_stop), .ch_pause_o(ch_pause), .ch_bound_o(ch_bound)
  );

  initial for (int c = 0; c < NC; c++) begin st_cnt[c] = 0; st_cyc[c] = 0; end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (grant_vld && g_n < 256) begin
        gl_req[g_n] = int'(grant_req);
        gl_ch[g_n]  = int'(grant_ch);
        gl_cyc[g_n] = cyc;
        g_n++;
      end
      for (int c = 0; c < NC; c++)
        if (ch_start[c]) begin st_cnt[c]++; st_cyc[c] = cyc; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_grant(input string tag, input int idx, input int req, input int ch);
    chk({tag, " grant requester"}, gl_req[idx], req);
    chk({tag, " grant channel"}, gl_ch[idx], ch);
  endtask

  // caller sits at a negedge; returns at the following negedge
  task automatic send(input int op, input int id, input bit w);
    cmd_vld = 1'b1; cmd_op = 2'(op); cmd_req = 6'(id); cmd_work = w;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_work = 1'b0;
  endtask

  task automatic done(input int ch, input bit more);
    ch_done[ch] = 1'b1; ch_more[ch] = more;
    @(negedge clk);
    ch_done = '0; ch_more = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_vld = 1'b0; ch_done = '0; ch_more = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fill_all();
    for (int r = 0; r < NC; r++) send(0, r, 1'b0);
    idle(40);
  endtask

  task automatic t_reset();
    chk("R1 bound in reset", int'(ch_bound), 0);
    do_reset();
    chk("R1 bound", int'(ch_bound), 0);
    chk("R1 pause", int'(ch_pause), 0);
    chk("R1 start", int'(ch_start), 0);
    chk("R1 stop", int'(ch_stop), 0);
    chk("R1 grant", int'(grant_vld), 0);
  endtask

  task automatic t_order();
    int b;
    do_reset(); b = g_n;
    send(0, 5, 0); send(0, 9, 0); send(0, 5, 0); send(0, 2, 0);
    idle(40);
    chk("R2 duplicate refused, grant count", g_n - b, 3);
    chk_grant("R3 first", b, 5, 0);
    chk_grant("R3 second", b + 1, 9, 1);
    chk_grant("R3 third", b + 2, 2, 2);
    chk("R4 one per cycle a", gl_cyc[b+1] - gl_cyc[b], 1);
    chk("R4 one per cycle b", gl_cyc[b+2] - gl_cyc[b+1], 1);
    chk("R4 start ch0", st_cnt[0], 1);
    chk("R4 start ch2", st_cnt[2], 1);
    chk("R4 starts together", st_cyc[0] == st_cyc[1] && st_cyc[1] == st_cyc[2], 1);
    chk("R4 start after last grant", st_cyc[0] > gl_cyc[b+2], 1);
    send(0, 9, 0); idle(30);
    chk("R2 bound issue ignored", g_n - b, 3);
  endtask

  task automatic t_lowest();
    int b;
    do_reset();
    for (int r = 1; r <= 4; r++) send(0, r, 0);
    idle(40);
    done(1, 1'b0);
    chk("R6 released", int'(ch_bound[4:0]), 5'b01101);
    b = g_n;
    send(0, 20, 0); send(0, 21, 0);
    idle(40);
    chk("R3 count", g_n - b, 2);
    chk_grant("R3 lowest free", b, 20, 1);
    chk_grant("R3 next free", b + 1, 21, 4);
  endtask

  task automatic t_more();
    int b, s;
    do_reset();
    send(0, 7, 0); idle(30);
    b = g_n; s = st_cnt[0];
    done(0, 1'b1);
    chk("R5 restart pulse", int'(ch_start[0]), 1);
    idle(10);
    chk("R5 still bound", int'(ch_bound[0]), 1);
    chk("R5 no grant", g_n - b, 0);
    chk("R5 start count", st_cnt[0] - s, 1);
  endtask

  task automatic t_pause();
    int b;
    do_reset(); fill_all();
    send(0, 30, 0);
    send(1, 30, 0);
    b = g_n;
    done(5, 1'b0);
    idle(30);
    chk("R7 paused requester not granted", g_n - b, 0);
    send(2, 30, 0); idle(30);
    chk("R8 resume without work", g_n - b, 0);
    send(2, 30, 1); idle(30);
    chk("R8 resume with work count", g_n - b, 1);
    chk_grant("R8 resumed", b, 30, 5);
    send(1, 3, 0);
    chk("R7 bound pause", int'(ch_pause[3]), 1);
    send(2, 3, 0);
    chk("R8 bound resume", int'(ch_pause[3]), 0);
  endtask

  task automatic t_term();
    int b;
    do_reset(); fill_all();
    b = g_n;
    send(0, 40, 0); send(0, 41, 0);
    send(3, 40, 0);
    send(1, 2, 0);
    chk("R7 pause before terminate", int'(ch_pause[2]), 1);
    send(3, 2, 0);
    chk("R9 stop pulse", int'(ch_stop[2]), 1);
    chk("R9 unbound", int'(ch_bound[2]), 0);
    chk("R9 pause cleared", int'(ch_pause[2]), 0);
    @(negedge clk);
    chk("R9 stop single cycle", int'(ch_stop[2]), 0);
    idle(40);
    chk("R9 terminated requester dropped", g_n - b, 1);
    chk_grant("R9 next waiter", b, 41, 2);
  endtask

  task automatic t_collide();
    int b, s;
    do_reset();
    send(0, 8, 0); idle(30);
    b = g_n;
    ch_done[0] = 1'b1; ch_more[0] = 1'b0;
    send(0, 8, 0);
    ch_done = '0;
    idle(40);
    chk("R10 regranted count", g_n - b, 1);
    chk_grant("R10 regrant", b, 8, 0);
    chk("R10 bound again", int'(ch_bound[0]), 1);
    b = g_n; s = st_cnt[0];
    ch_done[0] = 1'b1; ch_more[0] = 1'b1;
    send(0, 8, 0);
    ch_done = '0; ch_more = '0;
    idle(30);
    chk("R5 restart with issue, no grant", g_n - b, 0);
    chk("R5 restart with issue, start", st_cnt[0] - s, 1);
  endtask

  task automatic t_stall();
    int b;
    do_reset(); b = g_n;
    send(0, 10, 0); send(0, 11, 0);
    for (int i = 0; i < 8; i++) send(1, 50, 0);
    chk("R11 scan held by commands", g_n - b, 0);
    idle(30);
    chk("R11 grants after stall", g_n - b, 2);
    chk_grant("R11 first", b, 10, 0);
    chk_grant("R11 second", b + 1, 11, 1);
    send(0, 60, 0); idle(30);
    chk("R11 out of range ignored", g_n - b, 2);
    chk("R11 bound set", int'(ch_bound), 3);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_lowest();
    t_more();
    t_pause();
    t_term();
    t_collide();
    t_stall();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule